// File: doc/BRIEF.md
# MDIO Management Register Controller

This block lets a host reach the management registers of an external Ethernet PHY through a single 32-bit register. Software writes one command word. The word holds a read/write opcode, a PHY address, a register offset and, for a write, 16 data bits. The controller checks the address fields and then serialises a clause-22 management frame on an MDC/MDIO pair. The status is reported back in the same register, so software polls the busy and read-valid flags there and collects the returned data from the low half of the word.

MDC is derived from the system clock by a parameterised divider. `HALF_DIV` system clocks make one MDC half period, so one frame bit lasts `2*HALF_DIV` clocks. Every frame is 64 bits long, which makes a transaction last exactly `128*HALF_DIV` clocks. The MDIO pad is split into an output, an output enable and an input. The controller releases the line during the turnaround and the data phase of a read, when the PHY drives it.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the register reads 0x00000000, `mdc` is low and `mdio_oe` is low.
- R2: A command is accepted when `cmd_wr` is high, busy is low and both address fields are in range. Busy (register bit 30) then reads 1 from the cycle after the accepting edge, and it stays 1 for exactly 128*HALF_DIV cycles.
- R3: A command written while busy is high has no effect on the register or on the frame in progress. This includes a write on the very edge at which busy clears.
- R4: Command bits [21:16] form the register-offset field and bits [27:22] form the PHY-address field. Only values 0..31 are valid. If bit 21 or bit 27 is set, the command is rejected: no frame starts and the register is left unchanged, including the read-valid flag.
- R5: `mdc` is low whenever no transaction runs. During a transaction each frame bit takes 2*HALF_DIV cycles: `mdc` is low for the first HALF_DIV cycles and high for the second.
- R6: A write frame drives these bits, MSB first: 32 ones, start 01, opcode 01, the 5-bit PHY address, the 5-bit register offset, turnaround 10, then the 16 data bits. The output enable is high for all 64 bits, and a new bit appears with each falling MDC edge.
- R7: A read frame uses opcode 10. The output enable is high through bit 45 (the last register-offset bit) and low for the turnaround and the 16 data bits.
- R8: In a read, each data bit is sampled from `mdio_i` on the rising MDC edge of its bit, MSB first. When busy clears, bits [15:0] hold the 16 sampled bits and read-valid (bit 29) is 1.
- R9: An accepted command clears read-valid. While a read is in progress, bits [15:0] read zero.
- R10: Register readback is laid out as follows. Bits [15:0] hold the data. Bits [20:16] hold the offset, with bit 21 reading 0. Bits [26:22] hold the PHY address, with bit 27 reading 0. Bit 28 is the opcode (1 = read, 0 = write), bit 29 is read-valid, bit 30 is busy and bit 31 reads 0. The fields show the last accepted command, and for a write the data field shows the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe, one cycle |
| cmd_wdata | input | 29 | Command word: data, offset field, PHY field, opcode |
| reg_rdata | output | 32 | Register readback with flags and data |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value from the pad |

## Verification
When a command is accepted at clock edge E0, busy and the new fields are visible from the cycle after E0. `mdc` toggles after E0+k*HALF_DIV, and frame bit b is presented from E0+2*b*HALF_DIV. Busy and read-valid change together at E0+128*HALF_DIV. The bench keeps a behavioural model that counts cycles since acceptance and derives all of these from that count. It compares every output at each falling clock edge, after the edge that produced it. The bench plays the PHY: it presents the correct reply bit only in the cycle before the sampling edge of each data bit and the complement in every other cycle, so a sample taken one cycle early or late gives a visible mismatch.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 5;
  localparam int FIELD_W    = ADDR_W + 1;
  localparam int REG_LSB    = DATA_W;
  localparam int PHY_LSB    = REG_LSB + FIELD_W;
  localparam int OP_BIT     = PHY_LSB + FIELD_W;
  localparam int CMD_W      = OP_BIT + 1;
  localparam int RVAL_BIT   = OP_BIT + 1;
  localparam int BUSY_BIT   = OP_BIT + 2;
  localparam int RDATA_W    = 32;
  localparam int PRE_LEN    = 32;
  localparam int TA_START   = PRE_LEN + 4 + 2 * ADDR_W;
  localparam int DATA_START = TA_START + 2;
  localparam int FRAME_LEN  = DATA_START + DATA_W;
  localparam int BIT_W      = $clog2(FRAME_LEN);

  typedef struct packed {
    logic              is_read;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic [DATA_W-1:0] wdata;
  } mdio_cmd_t;

  // Complete serial image of one frame, first bit in the MSB.
  function automatic logic [FRAME_LEN-1:0] build_frame(input mdio_cmd_t c);
    logic [1:0]        op;
    logic [1:0]        ta;
    logic [DATA_W-1:0] dat;
    op  = c.is_read ? 2'b10 : 2'b01;
    ta  = c.is_read ? 2'b11 : 2'b10;
    dat = c.is_read ? {DATA_W{1'b1}} : c.wdata;
    return {{PRE_LEN{1'b1}}, 2'b01, op, c.phy, c.regad, ta, dat};
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  logic mdc_q, mdc_d;
  logic wrap;

  generate
    if (HALF_DIV > 1) begin : g_count
      localparam int CW = $clog2(HALF_DIV);
      logic [CW-1:0] cnt_q, cnt_d;

      assign wrap = (cnt_q == CW'(HALF_DIV - 1));

      always_comb begin
        cnt_d = cnt_q;
        if (!run)      cnt_d = '0;
        else if (wrap) cnt_d = '0;
        else           cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end else begin : g_direct
      assign wrap = 1'b1;
    end
  endgenerate

  always_comb begin
    mdc_d = mdc_q;
    if (!run)      mdc_d = 1'b0;
    else if (wrap) mdc_d = ~mdc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mdc_q <= 1'b0;
    else        mdc_q <= mdc_d;
  end

  assign mdc      = mdc_q;
  assign rise_evt = run & wrap & ~mdc_q;
  assign fall_evt = run & wrap &  mdc_q;
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mdio_cmd_t         cmd,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              mdio_i,
  output logic              run,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic                 run_q, run_d;
  logic [BIT_W-1:0]     bit_q, bit_d;
  logic [FRAME_LEN-1:0] frame_q, frame_d;
  logic                 rd_q, rd_d;
  logic [DATA_W-1:0]    rx_q, rx_d;
  logic                 last_bit;

  assign last_bit = (bit_q == BIT_W'(FRAME_LEN - 1));
  assign done     = run_q & fall_evt & last_bit;

  always_comb begin
    run_d   = run_q;
    bit_d   = bit_q;
    frame_d = frame_q;
    rd_d    = rd_q;
    rx_d    = rx_q;
    if (start && !run_q) begin
      run_d   = 1'b1;
      bit_d   = '0;
      frame_d = build_frame(cmd);
      rd_d    = cmd.is_read;
      rx_d    = '0;
    end else if (run_q) begin
      if (rise_evt && rd_q && (bit_q >= BIT_W'(DATA_START)))
        rx_d = {rx_q[DATA_W-2:0], mdio_i};
      if (fall_evt) begin
        if (last_bit) begin
          run_d = 1'b0;
        end else begin
          bit_d   = bit_q + 1'b1;
          frame_d = {frame_q[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      bit_q   <= '0;
      frame_q <= '0;
      rd_q    <= 1'b0;
      rx_q    <= '0;
    end else begin
      run_q   <= run_d;
      bit_q   <= bit_d;
      frame_q <= frame_d;
      rd_q    <= rd_d;
      rx_q    <= rx_d;
    end
  end

  assign run     = run_q;
  assign rd_data = rx_q;
  assign mdio_o  = run_q ? frame_q[FRAME_LEN-1] : 1'b1;
  assign mdio_oe = run_q & (~rd_q | (bit_q < BIT_W'(TA_START)));
endmodule

// File: rtl/mdio_host_reg.sv
module mdio_host_reg
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic [CMD_W-1:0]   cmd_wdata,
  input  logic               busy,
  input  logic               done,
  input  logic [DATA_W-1:0]  rd_data,
  output logic               start,
  output mdio_cmd_t          cmd_new,
  output logic [RDATA_W-1:0] reg_rdata
);
  logic              fields_ok;
  logic              rd_q, rd_d;
  logic [ADDR_W-1:0] phy_q, phy_d;
  logic [ADDR_W-1:0] regad_q, regad_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              rval_q, rval_d;

  assign cmd_new.is_read = cmd_wdata[OP_BIT];
  assign cmd_new.phy     = cmd_wdata[PHY_LSB +: ADDR_W];
  assign cmd_new.regad   = cmd_wdata[REG_LSB +: ADDR_W];
  assign cmd_new.wdata   = cmd_wdata[DATA_W-1:0];

  assign fields_ok = ~cmd_wdata[PHY_LSB + FIELD_W - 1] & ~cmd_wdata[REG_LSB + FIELD_W - 1];
  assign start     = cmd_wr & ~busy & fields_ok;

  always_comb begin
    rd_d    = rd_q;
    phy_d   = phy_q;
    regad_d = regad_q;
    data_d  = data_q;
    rval_d  = rval_q;
    if (start) begin
      rd_d    = cmd_new.is_read;
      phy_d   = cmd_new.phy;
      regad_d = cmd_new.regad;
      data_d  = cmd_new.is_read ? '0 : cmd_new.wdata;
      rval_d  = 1'b0;
    end else if (done && rd_q) begin
      data_d  = rd_data;
      rval_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      phy_q   <= '0;
      regad_q <= '0;
      data_q  <= '0;
      rval_q  <= 1'b0;
    end else begin
      rd_q    <= rd_d;
      phy_q   <= phy_d;
      regad_q <= regad_d;
      data_q  <= data_d;
      rval_q  <= rval_d;
    end
  end

  assign reg_rdata = {1'b0, busy, rval_q, rd_q, 1'b0, phy_q, 1'b0, regad_q, data_q};
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic [CMD_W-1:0]   cmd_wdata,
  output logic [RDATA_W-1:0] reg_rdata,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  input  logic               mdio_i
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              start, run, done, rise_evt, fall_evt;
  mdio_cmd_t         cmd_new;
  logic [DATA_W-1:0] rd_data;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mdio_host_reg u_host (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cmd_wr    (cmd_wr),
    .cmd_wdata (cmd_wdata),
    .busy      (run),
    .done      (done),
    .rd_data   (rd_data),
    .start     (start),
    .cmd_new   (cmd_new),
    .reg_rdata (reg_rdata)
  );

  mdio_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (run),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  mdio_frame_eng u_eng (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (start),
    .cmd      (cmd_new),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .mdio_i   (mdio_i),
    .run      (run),
    .done     (done),
    .rd_data  (rd_data),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
  );
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr,
  input logic        cmd_bad,
  input logic [31:0] reg_rdata,
  input logic        mdc,
  input logic        mdio_oe
);
  logic busy, rval, is_rd;
  assign busy  = reg_rdata[30];
  assign rval  = reg_rdata[29];
  assign is_rd = reg_rdata[28];

  assert_busy_needs_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_wr));

  assert_fields_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(reg_rdata[28:16]));

  assert_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && cmd_bad) |=> !busy);

  assert_mdc_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  assert_release_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mdio_oe) && busy) |-> is_rd);

  assert_valid_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rval) |-> $fell(busy));

  assert_valid_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !rval);
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_wr    (cmd_wr),
  .cmd_bad   (cmd_wdata[27] | cmd_wdata[21]),
  .reg_rdata (reg_rdata),
  .mdc       (mdc),
  .mdio_oe   (mdio_oe)
);

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF  = 4;
  localparam int TOTAL = 128 * HALF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_wr;
  logic [28:0] cmd_wdata;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string cur_tag = "R10";

  // behavioural model
  bit        m_busy = 0;
  int        m_t = 0;
  bit        m_rd = 0;
  bit [4:0]  m_phy = 0;
  bit [4:0]  m_reg = 0;
  bit [15:0] m_data = 0;
  bit        m_rval = 0;
  bit [15:0] m_reply = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_mgmt_ctrl #(.HALF_DIV(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", req, cycles, act, exp);
    end
  endtask

  function automatic bit exp_bit(input int b);
    if (b < 32)  return 1'b1;
    if (b == 32) return 1'b0;
    if (b == 33) return 1'b1;
    if (b == 34) return m_rd;
    if (b == 35) return !m_rd;
    if (b <= 40) return m_phy[40-b];
    if (b <= 45) return m_reg[45-b];
    if (b == 46) return 1'b1;
    if (b == 47) return 1'b0;
    return m_data[63-b];
  endfunction

  function automatic logic [28:0] mk(input bit rd, input bit [4:0] phy, input bit [4:0] ra,
                                     input bit [15:0] d);
    return {rd, 1'b0, phy, 1'b0, ra, d};
  endfunction

  task automatic compare();
    int  b;
    bit  e_mdc, e_oe;
    b     = m_t / (2 * HALF);
    e_mdc = m_busy && (((m_t / HALF) % 2) == 1);
    e_oe  = m_busy && (!m_rd || b < 46);
    check("R2", {31'd0, reg_rdata[30]}, {31'd0, m_busy});
    check("R5", {31'd0, mdc}, {31'd0, e_mdc});
    check(m_rd ? "R7" : "R6", {31'd0, mdio_oe}, {31'd0, e_oe});
    if (e_oe) check(m_rd ? "R7" : "R6", {31'd0, mdio_o}, {31'd0, exp_bit(b)});
    check(cur_tag, reg_rdata,
          {1'b0, m_busy, m_rval, m_rd, 1'b0, m_phy, 1'b0, m_reg, m_data});
  endtask

  task automatic tick();
    int b;
    mdio_i = 1'b1;
    if (m_busy && m_rd) begin
      b = m_t / (2 * HALF);
      if (b >= 48)
        mdio_i = ((m_t % (2 * HALF)) == HALF - 1) ? m_reply[63-b] : !m_reply[63-b];
    end
    if (m_busy) begin
      m_t++;
      if (m_t == TOTAL) begin
        m_busy = 0;
        if (m_rd) begin m_rval = 1; m_data = m_reply; end
      end
    end else if (cmd_wr && !cmd_wdata[27] && !cmd_wdata[21]) begin
      m_busy = 1; m_t = 0;
      m_rd   = cmd_wdata[28];
      m_phy  = cmd_wdata[26:22];
      m_reg  = cmd_wdata[20:16];
      m_data = m_rd ? 16'h0 : cmd_wdata[15:0];
      m_rval = 0;
    end
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic issue(input logic [28:0] w);
    cmd_wr = 1'b1; cmd_wdata = w;
    tick();
    cmd_wr = 1'b0; cmd_wdata = '0;
  endtask

  task automatic wait_idle();
    while (m_busy) tick();
    tick();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_wr = 1'b0; cmd_wdata = '0; mdio_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", reg_rdata, 32'h0);
    check("R1", {30'd0, mdc, mdio_oe}, 32'h0);

    // R6 / R10: write frame, then a command while busy (R3)
    cur_tag = "R10";
    issue(mk(0, 5'd5, 5'h12, 16'hA5C3));
    repeat (40) tick();
    cur_tag = "R3";
    issue(mk(1, 5'd9, 5'd3, 16'h1234));
    wait_idle();

    // R7 / R8: read with reply, R9 data reads zero while in progress
    cur_tag = "R9";
    m_reply = 16'hBEEF;
    issue(mk(1, 5'h1F, 5'd0, 16'h7777));
    wait_idle();
    check("R8", {16'd0, reg_rdata[15:0]}, 32'h0000BEEF);
    check("R8", {31'd0, reg_rdata[29]}, 32'd1);

    // R4: out-of-range fields rejected, read-valid untouched
    cur_tag = "R4";
    issue(29'h0800_0000 | mk(0, 5'd1, 5'd1, 16'h1111));
    tick();
    check("R4", {31'd0, reg_rdata[30]}, 32'd0);
    check("R4", {31'd0, reg_rdata[29]}, 32'd1);
    issue(29'h0020_0000 | mk(0, 5'd2, 5'd2, 16'h2222));
    tick();
    check("R4", {16'd0, reg_rdata[15:0]}, 32'h0000BEEF);

    // R9: accepted command clears read-valid
    cur_tag = "R9";
    issue(mk(0, 5'd0, 5'd31, 16'hFFFF));
    check("R9", {31'd0, reg_rdata[29]}, 32'd0);
    wait_idle();

    // boundary read: PHY 0, offset 31, reply 0x0001
    cur_tag = "R10";
    m_reply = 16'h0001;
    issue(mk(1, 5'd0, 5'd31, 16'h0));
    wait_idle();
    check("R8", {16'd0, reg_rdata[15:0]}, 32'h00000001);

    // R3: command on the edge where busy clears is ignored; next one accepted
    cur_tag = "R3";
    m_reply = 16'h8000;
    issue(mk(1, 5'd17, 5'd8, 16'h0));
    while (m_t < TOTAL - 1) tick();
    issue(mk(0, 5'd3, 5'd4, 16'h5A5A));
    check("R3", {31'd0, reg_rdata[30]}, 32'd0);
    check("R8", {16'd0, reg_rdata[15:0]}, 32'h00008000);
    issue(mk(0, 5'd3, 5'd4, 16'h5A5A));
    check("R2", {31'd0, reg_rdata[30]}, 32'd1);
    wait_idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule